// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Sequencer

This block decides, for one synchronous-rectifier channel, when the gate command rises and when it falls. It works on clock-sampled comparator flags: the drain has dropped below the turn-on level, the drain has climbed above the turn-off level, and the drain has climbed above the drain-high level. It also watches the gate of the opposite channel. All timing is counted in clock cycles. The window lengths come from one variant selector: a high-frequency set or a low-frequency set.

A turn-on request must hold for a debounce time before the gate rises. The gate is also refused while the opposite gate is on, and for a short lockout after that gate falls. Once the gate is on, the block measures the conduction time, from the gate rising to the drain going high. That value is saved and used to size two windows in the next cycle. The blanking window is a quarter of the saved value, clamped to a range, and turn-off flags are ignored inside it. The inversion window is one sixteenth of the saved value. If the turn-off flag stays high for the whole inversion window, the current has reversed and the gate drops at once.

An inversion puts the channel into a sticky state that uses a much longer turn-on debounce. That state clears only after a run of clean gate pulses. A maximum on-time limit forces the gate off if nothing else does.

Top module: `sr_gate_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `gate_o` is 0 and `cond_time_o` is 0.
- R2: The gate rises exactly D clock edges after the first edge that samples `drain_on_i` high, provided `drain_on_i` stays high through those edges. D is 4 in the normal state and 42 in the inversion-recovery state (high-frequency set). If `drain_on_i` falls before that, the gate does not rise.
- R3: `cond_time_o` becomes j, where j counts clock edges from the edge that raises the gate to the first edge that samples `drain_high_i` high. The count saturates at 2^CNT_W-1 (4095 by default). The value is held until the next measurement completes.
- R4: The blanking window is B = clamp(C/4, 10, 60), where C is the saved conduction time (the high-frequency set). Let e count edges since the gate rose. A lone `drain_off_i` sample at e < B is ignored. A sample at e >= B turns the gate off at that edge.
- R5: The inversion window is W = max(C/16, 2). Suppose `drain_off_i` is sampled high at W consecutive edges while the gate is on. The gate then turns off at the W-th such edge, even inside the blanking window. This is an inversion event.
- R6: An inversion event enters the recovery state, which uses the long debounce. Any gate pulse that ends without an inversion is a clean pulse. The state clears after 7 consecutive clean pulses, so the pulse after them uses the normal debounce again. An inversion during recovery restarts the count of 7.
- R7: If nothing else turns the gate off, it is forced off after 750 cycles on (high-frequency set).
- R8: No turn-on starts while `peer_gate_i` is high. No turn-on starts at the edge that samples `peer_gate_i` falling, nor at the 9 edges after it (10 edges blocked in total). A request that meets the block is dropped, not queued. The gate stays off until `drain_on_i` goes low and is asserted again.
- R9: Each assertion of `drain_on_i` gives at most one gate pulse. After the gate falls, it does not rise again until `drain_on_i` has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_on_i | input | 1 | Drain below the turn-on level |
| drain_off_i | input | 1 | Drain above the turn-off level |
| drain_high_i | input | 1 | Drain above the drain-high level |
| peer_gate_i | input | 1 | Gate state of the opposite channel |
| gate_o | output | 1 | Gate command |
| cond_time_o | output | CNT_W | Conduction time saved from the last measurement, in cycles |

## Verification
Some properties are checked on every cycle:
- The gate never stays on past the maximum on-time.
- The gate never rises when the lockout was active, or when no request was present, in the cycle before.
- An inversion event always takes the gate down on the next cycle.
- A normal turn-off only happens after blanking.
- The saved conduction time only changes when a drain-high sample ends a measurement.
- The lockout counter stays within its bound.

Other behaviour only the bench scenarios can show. These are the exact lengths of the blanking and inversion windows as the saved conduction time is swept, and the exact debounce delays. They also cover the count of clean pulses before recovery ends, and its restart after a new inversion. Saturation of the measurement, and the fact that a blocked request is never queued, are shown the same way.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_ON,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        OFF_NONE,
        OFF_NORMAL,
        OFF_INVERT,
        OFF_MAXON
    } off_cause_e;

    // Window lengths in clock cycles for one frequency variant.
    typedef struct packed {
        logic [15:0] deb_norm;
        logic [15:0] deb_long;
        logic [15:0] min_lo;
        logic [15:0] min_hi;
        logic [15:0] max_on;
        logic [15:0] lock;
    } timing_t;

    function automatic timing_t variant_timing(input logic low_freq);
        timing_t t;
        if (low_freq) begin
            t.deb_norm = 16'd4;
            t.deb_long = 16'd55;
            t.min_lo   = 16'd20;
            t.min_hi   = 16'd200;
            t.max_on   = 16'd1500;
            t.lock     = 16'd10;
        end else begin
            t.deb_norm = 16'd4;
            t.deb_long = 16'd42;
            t.min_lo   = 16'd10;
            t.min_hi   = 16'd60;
            t.max_on   = 16'd750;
            t.lock     = 16'd10;
        end
        return t;
    endfunction

    // Blanking: a quarter of the saved conduction time, clamped.
    function automatic int blank_window(input int prev, input int lo, input int hi);
        int q;
        q = prev >> 2;
        if (q < lo) q = lo;
        if (q > hi) q = hi;
        return q;
    endfunction

    // Inversion: one sixteenth of the saved conduction time, with a floor.
    function automatic int invert_window(input int prev, input int floor_v);
        int q;
        q = prev >> 4;
        if (q < floor_v) q = floor_v;
        return q;
    endfunction

endpackage

// File: rtl/sr_lockout.sv
module sr_lockout #(
    parameter int LOCK_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic peer_gate_i,
    output logic busy_o
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic          peer_q;
    logic [LW-1:0] cnt_q;
    logic          peer_fall;

    assign peer_fall = peer_q & ~peer_gate_i;
    assign busy_o    = peer_gate_i | peer_fall | (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            peer_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            peer_q <= peer_gate_i;
            if (peer_fall)
                cnt_q <= LW'(LOCK_CYC - 1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - LW'(1);
        end
    end

    // R8: the lockout counter never exceeds its window
    p_lock_bound_r8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= LOCK_CYC - 1);

endmodule

// File: rtl/sr_cond_meter.sv
module sr_cond_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             drain_high_i,
    output logic [CNT_W-1:0] cond_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic             meas_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt_q == SAT) ? SAT : cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            meas_q <= 1'b0;
            cnt_q  <= '0;
            cond_o <= '0;
        end else if (start_i) begin
            meas_q <= 1'b1;
            cnt_q  <= '0;
        end else if (meas_q) begin
            if (drain_high_i) begin
                cond_o <= cnt_inc;
                meas_q <= 1'b0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // R3: the saved value changes only when a drain-high sample ends a measurement
    p_cond_update_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cond_o) |-> $past(meas_q && drain_high_i && !start_i));

endmodule

// File: rtl/sr_inv_tracker.sv
module sr_inv_tracker #(
    parameter int CLEAN_RUN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic end_i,
    input  logic inv_i,
    output logic long_o
);
    localparam int CW = $clog2(CLEAN_RUN + 1);

    logic [CW-1:0] clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            long_o  <= 1'b0;
            clean_q <= '0;
        end else if (end_i) begin
            if (inv_i) begin
                long_o  <= 1'b1;
                clean_q <= '0;
            end else if (long_o) begin
                if (int'(clean_q) + 1 >= CLEAN_RUN) begin
                    long_o  <= 1'b0;
                    clean_q <= '0;
                end else begin
                    clean_q <= clean_q + CW'(1);
                end
            end
        end
    end

    // R6: recovery is entered only through an inversion event
    p_long_entry_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(long_o) |-> $past(end_i && inv_i));

    // R6: recovery is left only at the end of a clean pulse
    p_long_exit_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(long_o) |-> $past(end_i && !inv_i));

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
    import sr_seq_pkg::*;
#(
    parameter logic LOW_FREQ  = 1'b0,
    parameter int   CNT_W     = 12,
    parameter int   CLEAN_RUN = 7,
    parameter int   INV_FLOOR = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drain_on_i,
    input  logic             drain_off_i,
    input  logic             drain_high_i,
    input  logic             peer_gate_i,
    output logic             gate_o,
    output logic [CNT_W-1:0] cond_time_o
);
    localparam timing_t TM = variant_timing(LOW_FREQ);
    localparam logic [CNT_W-1:0] MAX_ON   = CNT_W'(TM.max_on);
    localparam logic [CNT_W-1:0] DEB_NORM = CNT_W'(TM.deb_norm);
    localparam logic [CNT_W-1:0] DEB_LONG = CNT_W'(TM.deb_long);
    localparam int MIN_LO = int'(TM.min_lo);
    localparam int MIN_HI = int'(TM.min_hi);
    localparam int LOCK   = int'(TM.lock);

    seq_state_e       state_q, state_n;
    off_cause_e       cause;
    logic [CNT_W-1:0] el_q, el_n;
    logic [CNT_W-1:0] run_q, run_n, run_inc;
    logic [CNT_W-1:0] deb_q, deb_n;
    logic [CNT_W-1:0] min_on_w, inv_win_w, deb_tgt;
    logic             lock_busy, long_delay;
    logic             gate_rise, off_evt, inv_evt;

    sr_lockout #(.LOCK_CYC(LOCK)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .peer_gate_i (peer_gate_i),
        .busy_o      (lock_busy)
    );

    sr_cond_meter #(.CNT_W(CNT_W)) u_meter (
        .clk          (clk),
        .rst          (rst),
        .start_i      (gate_rise),
        .drain_high_i (drain_high_i),
        .cond_o       (cond_time_o)
    );

    sr_inv_tracker #(.CLEAN_RUN(CLEAN_RUN)) u_inv (
        .clk    (clk),
        .rst    (rst),
        .end_i  (off_evt),
        .inv_i  (inv_evt),
        .long_o (long_delay)
    );

    assign min_on_w  = CNT_W'(blank_window(int'(cond_time_o), MIN_LO, MIN_HI));
    assign inv_win_w = CNT_W'(invert_window(int'(cond_time_o), INV_FLOOR));
    assign deb_tgt   = long_delay ? DEB_LONG : DEB_NORM;
    assign run_inc   = drain_off_i ? run_q + CNT_W'(1) : '0;
    assign gate_o    = (state_q == ST_ON);

    // Turn-off cause: inversion wins over a normal turn-off, which wins over the limit.
    always_comb begin
        cause = OFF_NONE;
        if (drain_off_i && run_inc >= inv_win_w)
            cause = OFF_INVERT;
        else if (drain_off_i && el_q >= min_on_w)
            cause = OFF_NORMAL;
        else if (el_q >= MAX_ON)
            cause = OFF_MAXON;
    end

    always_comb begin
        state_n   = state_q;
        el_n      = el_q;
        run_n     = run_q;
        deb_n     = deb_q;
        gate_rise = 1'b0;
        off_evt   = 1'b0;
        inv_evt   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (drain_on_i) begin
                    if (lock_busy) begin
                        state_n = ST_WAIT;
                    end else begin
                        state_n = ST_DEBOUNCE;
                        deb_n   = '0;
                    end
                end
            end
            ST_DEBOUNCE: begin
                if (!drain_on_i) begin
                    state_n = ST_IDLE;
                end else if (lock_busy) begin
                    state_n = ST_WAIT;
                end else if (deb_q + CNT_W'(1) >= deb_tgt) begin
                    state_n   = ST_ON;
                    gate_rise = 1'b1;
                    el_n      = CNT_W'(1);
                    run_n     = '0;
                end else begin
                    deb_n = deb_q + CNT_W'(1);
                end
            end
            ST_ON: begin
                if (cause != OFF_NONE) begin
                    state_n = ST_WAIT;
                    off_evt = 1'b1;
                    inv_evt = (cause == OFF_INVERT);
                end else begin
                    el_n  = el_q + CNT_W'(1);
                    run_n = run_inc;
                end
            end
            default: begin
                if (!drain_on_i) state_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            el_q    <= '0;
            run_q   <= '0;
            deb_q   <= '0;
        end else begin
            state_q <= state_n;
            el_q    <= el_n;
            run_q   <= run_n;
            deb_q   <= deb_n;
        end
    end

    // R7: the gate never stays on past the limit
    p_max_on_r7: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> (el_q <= MAX_ON));

    // R8: a rise needs a live request and a free lockout in the cycle before
    p_rise_unblocked_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> $past(drain_on_i && !lock_busy));

    // R5: an inversion event takes the gate down at once
    p_inv_off_r5: assert property (@(posedge clk) disable iff (rst)
        inv_evt |=> !gate_o);

    // R4: a non-inversion turn-off only happens after blanking or at the limit
    p_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (off_evt && !inv_evt) |-> (el_q >= min_on_w || el_q >= MAX_ON));

endmodule

// File: tb/sr_gate_seq_bench.sv
`timescale 1ns/1ps
module sr_gate_seq_bench;
    localparam int DEB_N = 4, DEB_L = 42, MLO = 10, MHI = 60, MAXON = 750;
    localparam int CLEAN = 7, FLOOR = 2, SATV = 4095;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drain_on = 1'b0, drain_off = 1'b0, drain_high = 1'b0, peer = 1'b0;
    logic gate;
    logic [11:0] cond;

    int checks = 0, errors = 0;
    int m_prev = 0, m_mode = 0, m_clean = 0;

    always #10 clk = ~clk;

    sr_gate_seq u_sr_gate_seq (
        .clk (clk), .rst (rst), .drain_on_i (drain_on), .drain_off_i (drain_off),
        .drain_high_i (drain_high), .peer_gate_i (peer),
        .gate_o (gate), .cond_time_o (cond)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blank_of(input int p);
        int q = p / 4;
        if (q < MLO) q = MLO;
        if (q > MHI) q = MHI;
        return q;
    endfunction

    function automatic int inv_of(input int p);
        int q = p / 16;
        return (q < FLOOR) ? FLOOR : q;
    endfunction

    function automatic bit off_at(input int e, input int a, input int b, input bit hold);
        if (hold) return (a > 0 && e >= a);
        return (a > 0 && e == a) || (b > 0 && e == b);
    endfunction

    // One full gate pulse; lat is the debounce in edges, len the edges on.
    task automatic do_cycle(input int high_at, input int a, input int b, input bit hold,
                            output int lat, output int len);
        int cnt = 0;
        len = -1;
        drain_on = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
        end while (!gate && cnt < 200);
        lat = cnt - 1;
        drain_on = 1'b0;
        for (int e = 1; e < 6000; e++) begin
            drain_off = off_at(e, a, b, hold);
            if (high_at > 0 && e >= high_at) drain_high = 1'b1;
            @(negedge clk);
            if (!gate && len < 0) len = e;
            if (len >= 0 && e >= high_at) break;
        end
        drain_off = 1'b0;
        drain_high = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_and_check(input string req, input int high_at, input int a,
                                 input int b, input bit hold);
        int lat, len, exp_len = MAXON, run = 0;
        bit inv = 0;
        for (int e = 1; e <= MAXON; e++) begin
            bit o = off_at(e, a, b, hold);
            run = o ? run + 1 : 0;
            if (o && run >= inv_of(m_prev)) begin exp_len = e; inv = 1; break; end
            if (o && e >= blank_of(m_prev)) begin exp_len = e; break; end
        end
        do_cycle(high_at, a, b, hold, lat, len);
        check(m_mode ? "R6 long debounce" : "R2 debounce", lat, m_mode ? DEB_L : DEB_N);
        check(req, len, exp_len);
        if (high_at > 0) m_prev = (high_at > SATV) ? SATV : high_at;
        check("R3 conduction time", int'(cond), m_prev);
        if (inv) begin m_mode = 1; m_clean = 0; end
        else if (m_mode == 1) begin
            m_clean++;
            if (m_clean >= CLEAN) begin m_mode = 0; m_clean = 0; end
        end
    endtask

    task automatic hold_no_gate(input string req, input int n);
        int seen = 0;
        repeat (n) begin @(negedge clk); if (gate) seen = 1; end
        check(req, seen, 0);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int sweep [8] = '{8, 36, 100, 240, 300, 480, 1000, 2000};
        repeat (3) @(negedge clk);
        check("R1 gate in reset", int'(gate), 0);
        check("R1 cond in reset", int'(cond), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 gate after reset", int'(gate), 0);
        check("R1 cond after reset", int'(cond), 0);

        // R2: request shorter than the debounce never raises the gate
        drain_on = 1'b1;
        repeat (3) @(negedge clk);
        drain_on = 1'b0;
        hold_no_gate("R2 short request", 12);

        // R4: sweep the saved conduction time and probe the blanking edge
        foreach (sweep[i]) begin
            run_and_check("R4 late turn-off", sweep[i], 70, 0, 1'b0);
            run_and_check("R4 blanking boundary", sweep[i],
                          blank_of(sweep[i]) - 2, blank_of(sweep[i]), 1'b0);
        end

        // R5: held turn-off flag where the inversion window exceeds blanking
        run_and_check("R5 held flag, no inversion", 400, 1, 0, 1'b1);
        // R5: inversion inside blanking, then the R6 recovery count
        run_and_check("R5 inversion", 400, 1, 0, 1'b1);
        repeat (3) run_and_check("R6 clean pulse", 400, 70, 0, 1'b0);
        run_and_check("R5 inversion in recovery", 100, 1, 0, 1'b1);
        repeat (7) run_and_check("R6 clean pulse", 100, 70, 0, 1'b0);
        run_and_check("R6 back to normal", 100, 70, 0, 1'b0);

        // R7: forced off at the limit
        run_and_check("R7 max on-time", 800, 0, 0, 1'b0);
        // R3: saturating measurement
        run_and_check("R3 saturation", 5000, 0, 0, 1'b0);
        run_and_check("R4 after saturation", 300, 70, 0, 1'b0);

        // R9: one pulse per request while the request stays high
        drain_on = 1'b1;
        while (!gate) @(negedge clk);
        repeat (69) @(negedge clk);
        drain_off = 1'b1;
        @(negedge clk);
        drain_off = 1'b0;
        check("R9 gate off after flag", int'(gate), 0);
        hold_no_gate("R9 no second pulse", 30);
        drain_on = 1'b0;
        repeat (3) @(negedge clk);

        // R8: peer gate high blocks
        peer = 1'b1;
        repeat (2) @(negedge clk);
        drain_on = 1'b1;
        hold_no_gate("R8 peer high", 20);
        drain_on = 1'b0;
        repeat (2) @(negedge clk);
        // R8: request at the last blocked edge is dropped, not queued
        peer = 1'b0;
        repeat (9) @(negedge clk);
        drain_on = 1'b1;
        hold_no_gate("R8 dropped request", 30);
        drain_on = 1'b0;
        repeat (2) @(negedge clk);
        // R8: request at the first free edge is served
        peer = 1'b1;
        repeat (2) @(negedge clk);
        peer = 1'b0;
        repeat (10) @(negedge clk);
        run_and_check("R8 first free edge", 300, 70, 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule